// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Model with Victim Buffer

This block models the tag side of a small direct-mapped data cache. The cache writes back dirty lines and allocates on writes. A small fully associative victim buffer sits behind it. Each reference gives an operation code and a byte address. The block looks the reference up in the main array and, if that misses, in the victim buffer. It then moves lines between the two structures. No data is stored. Only the presence, validity and dirtiness of each line are tracked.

Each accepted reference is classified as a main hit, a victim hit or a full miss. The result appears on the response port one clock after acceptance. Running counters accumulate references, each outcome, lines written back to memory and access cycles. A terminating marker closes the stream. After the marker the block holds its statistics until reset.

Top module: `dmvc_cache`

## Requirements
- R1: The address is split into a 3-bit byte offset (bits 2:0), a 4-bit set index (bits 6:3) and a 25-bit tag (bits 31:7). References that differ only in the offset belong to the same line.
- R2: `req_op` 1 is a read and 2 is a write. One clock after an accepted reference, `rsp_valid` is 1 and `rsp_kind` shows the outcome: 1 for a main hit, 2 for a victim hit, 3 for a full miss. The first reference to a line after reset is a miss, and a repeated reference is a main hit.
- R3: When a miss lands on a set whose main line is valid, that line moves to the victim buffer. A later reference to it is a victim hit. That line returns to the main array, and the main line it replaces takes its buffer slot.
- R4: The victim buffer holds 2 lines. A line goes into an empty slot when one exists; otherwise it replaces the least recently used slot. The slot just filled, or just swapped, becomes most recently used.
- R5: A valid dirty line dropped from the victim buffer counts as one write-back, and `rsp_wb` is 1 for that reference. Dropping a clean line counts nothing.
- R6: A write that hits in the main array or in the victim buffer leaves the line dirty in the main array. A write miss allocates the line dirty. Dirtiness travels with a line through every move.
- R7: `cnt_refs`, `cnt_main`, `cnt_vic` and `cnt_miss` each increase by one for their own event. `cnt_refs` always equals the sum of the other three.
- R8: `cnt_cycles` adds 1 for a main hit, 2 for a victim hit and 50 for a full miss.
- R9: Operation 0 with address 0 sets `done`. The marker itself is not counted. Every later reference is ignored until reset.
- R10: Operation 3, and operation 0 with a nonzero address, are ignored. They produce no response and change no counter or line state.
- R11: After reset, all counters are 0, `rsp_valid` and `done` are 0, and every line in both structures is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Reference present this cycle |
| req_op | input | 2 | Operation: 1 read, 2 write, 0 with address 0 ends the stream |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Outcome of the reference accepted last cycle |
| rsp_kind | output | 2 | 1 main hit, 2 victim hit, 3 full miss |
| rsp_wb | output | 1 | That reference caused a write-back |
| done | output | 1 | End marker seen |
| cnt_refs | output | 32 | Accepted references |
| cnt_main | output | 32 | Main-array hits |
| cnt_vic | output | 32 | Victim-buffer hits |
| cnt_miss | output | 32 | Full misses |
| cnt_wb | output | 32 | Lines written back |
| cnt_cycles | output | 32 | Accumulated access cycles |

## Verification
Line state cannot be seen directly, so corruption shows up later in the outcome of some reference. A lost or wrong tag turns an expected hit into a miss the next time that line is used. A wrong recency order sends the wrong line out of the buffer, and the error appears on the next reference to the dropped line. A lost dirty bit hides a write-back when that line finally leaves the buffer, which can be many references later. For this reason the bench sweeps long stretches of conflicting references over a few sets and compares every response with an arithmetic model of its own.

// File: rtl/dmvc_pkg.sv
// Shared types for the direct-mapped cache tag model.
// Assumes a 2-bit operation code; outcome codes are visible at the ports.
package dmvc_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_MAIN = 2'd1,
        KIND_VIC  = 2'd2,
        KIND_MISS = 2'd3
    } kind_e;

    localparam logic [1:0] OP_END = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_WR  = 2'd2;
endpackage

// File: rtl/dmvc_main_array.sv
// Direct-mapped tag store: one tag, valid and dirty bit per set.
// Reads are combinational on idx. A write fills the indexed set and marks it valid.
// Assumes the caller keeps idx stable while wr_en is asserted.
module dmvc_main_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  val_q;
    logic [SETS-1:0]  dty_q;

    // Valid and dirty flags; reset invalidates every set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            dty_q <= '0;
        end else if (wr_en) begin
            val_q[idx] <= 1'b1;
            dty_q[idx] <= wr_dirty;
        end
    end

    // Tag storage, meaningful only where the valid flag is set.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[idx] <= wr_tag;
    end

    // Combinational read of the indexed set.
    always_comb begin
        rd_tag   = tag_q[idx];
        rd_valid = val_q[idx];
        rd_dirty = dty_q[idx];
    end

    // A written set must read back as valid afterwards.
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> val_q[$past(idx)]);
endmodule

// File: rtl/dmvc_victim_buf.sv
// Fully associative victim buffer with full block addresses and LRU ages.
// Ages form a permutation 0..N-1, where 0 is the most recently used slot.
// A swap rewrites the slot that hit. A push fills the first empty slot,
// or the oldest slot when none is empty.
// Assumes upd_swap is only asserted while hit is high.
module dmvc_victim_buf #(
    parameter int BLK_W = 29,
    parameter int N     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] look_blk,
    output logic             hit,
    output logic             hit_dirty,
    input  logic             upd_en,
    input  logic             upd_swap,
    input  logic [BLK_W-1:0] new_blk,
    input  logic             new_valid,
    input  logic             new_dirty,
    output logic             drop_wb
);
    localparam int SLOT_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(N - 1);

    logic [BLK_W-1:0]  blk_q [N];
    logic [SLOT_W-1:0] age_q [N];
    logic [N-1:0]      v_q;
    logic [N-1:0]      d_q;
    logic [N-1:0]      hit_vec;
    logic [SLOT_W-1:0] hit_slot, push_slot, tgt_slot, tgt_age;
    logic              found_free;

    // Per-slot address comparators.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = v_q[i] && (blk_q[i] == look_blk);
    end

    // Encode the hit slot and pick the slot a push would fill.
    always_comb begin
        hit_slot   = '0;
        push_slot  = '0;
        found_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_slot = SLOT_W'(i);
            if (age_q[i] == OLDEST && !found_free) push_slot = SLOT_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (!v_q[i] && !found_free) begin
                push_slot  = SLOT_W'(i);
                found_free = 1'b1;
            end
        end
        tgt_slot  = upd_swap ? hit_slot : push_slot;
        tgt_age   = age_q[tgt_slot];
        hit       = |hit_vec;
        hit_dirty = d_q[hit_slot];
        drop_wb   = upd_en && !upd_swap && v_q[push_slot] && d_q[push_slot];
    end

    // Rewrite the target slot and age the slots that were more recent than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            d_q <= '0;
            for (int i = 0; i < N; i++) age_q[i] <= SLOT_W'(i);
        end else if (upd_en) begin
            for (int i = 0; i < N; i++) begin
                if (SLOT_W'(i) == tgt_slot) begin
                    blk_q[i] <= new_blk;
                    v_q[i]   <= new_valid;
                    d_q[i]   <= new_dirty;
                    age_q[i] <= '0;
                end else if (age_q[i] < tgt_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // A write-back is only possible once every slot is occupied.
    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_wb |-> (&v_q));

    // At most one slot may match a looked-up block.
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // Ages remain pairwise distinct, so the recency order is always total.
    for (genvar i = 0; i < N; i++) begin : g_age_chk
        for (genvar j = i + 1; j < N; j++) begin : g_pair
            p_ages_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
                age_q[i] != age_q[j]);
        end
    end
endmodule

// File: rtl/dmvc_stats.sv
// Statistics counters: references, one counter per outcome, write-backs and access cycles.
// Assumes acc_kind is one of the three outcome codes whenever acc_en is high.
module dmvc_stats
    import dmvc_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int COST_MAIN = 1,
    parameter int COST_VIC  = 2,
    parameter int COST_MISS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  kind_e            acc_kind,
    input  logic             acc_wb,
    output logic [CNT_W-1:0] refs,
    output logic [CNT_W-1:0] n_main,
    output logic [CNT_W-1:0] n_vic,
    output logic [CNT_W-1:0] n_miss,
    output logic [CNT_W-1:0] n_wb,
    output logic [CNT_W-1:0] cycles
);
    logic [CNT_W-1:0] cost;

    // Access cost of the current outcome.
    always_comb begin
        case (acc_kind)
            KIND_MAIN: cost = CNT_W'(COST_MAIN);
            KIND_VIC:  cost = CNT_W'(COST_VIC);
            default:   cost = CNT_W'(COST_MISS);
        endcase
    end

    // Bump the counters for one accepted reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs   <= '0;
            n_main <= '0;
            n_vic  <= '0;
            n_miss <= '0;
            n_wb   <= '0;
            cycles <= '0;
        end else if (acc_en) begin
            refs   <= refs + 1'b1;
            cycles <= cycles + cost;
            if (acc_wb) n_wb <= n_wb + 1'b1;
            case (acc_kind)
                KIND_MAIN: n_main <= n_main + 1'b1;
                KIND_VIC:  n_vic  <= n_vic + 1'b1;
                default:   n_miss <= n_miss + 1'b1;
            endcase
        end
    end

    // Every reference is counted under exactly one outcome.
    p_outcome_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refs == n_main + n_vic + n_miss);

    // The cycle total moves only by one of the three access costs.
    p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (cycles - $past(cycles) == CNT_W'(COST_MAIN)) ||
                   (cycles - $past(cycles) == CNT_W'(COST_VIC))  ||
                   (cycles - $past(cycles) == CNT_W'(COST_MISS)));
endmodule

// File: rtl/dmvc_cache.sv
// Top level of the tag-only direct-mapped cache with a victim buffer.
// Classifies each read or write, moves lines between the main array and the
// victim buffer, and reports the outcome one clock after acceptance.
// Assumes one reference per cycle at most. It applies no back-pressure.
module dmvc_cache
    import dmvc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 3,
    parameter int IDX_W     = 4,
    parameter int VIC_N     = 2,
    parameter int CNT_W     = 32,
    parameter int COST_MAIN = 1,
    parameter int COST_VIC  = 2,
    parameter int COST_MISS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic              rsp_wb,
    output logic              done,
    output logic [CNT_W-1:0]  cnt_refs,
    output logic [CNT_W-1:0]  cnt_main,
    output logic [CNT_W-1:0]  cnt_vic,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_wb,
    output logic [CNT_W-1:0]  cnt_cycles
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag, m_tag;
    logic [BLK_W-1:0] blk;
    logic             is_rd, is_wr, is_end, accept;
    logic             m_valid, m_dirty, main_hit;
    logic             v_hit, v_dirty, v_upd, drop_wb;
    logic             m_wr_en, m_wr_dirty;
    kind_e            kind;

    // Decode the request and split the address into its fields.
    always_comb begin
        idx    = req_addr[OFF_W +: IDX_W];
        tag    = req_addr[ADDR_W-1 -: TAG_W];
        blk    = req_addr[ADDR_W-1 -: BLK_W];
        is_rd  = (req_op == OP_RD);
        is_wr  = (req_op == OP_WR);
        is_end = (req_op == OP_END) && (req_addr == '0);
        accept = req_valid && !done && (is_rd || is_wr);
    end

    dmvc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) main_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .rd_tag   (m_tag),
        .rd_valid (m_valid),
        .rd_dirty (m_dirty),
        .wr_en    (m_wr_en),
        .wr_tag   (tag),
        .wr_dirty (m_wr_dirty)
    );

    dmvc_victim_buf #(.BLK_W(BLK_W), .N(VIC_N)) vic_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_blk  (blk),
        .hit       (v_hit),
        .hit_dirty (v_dirty),
        .upd_en    (v_upd),
        .upd_swap  (v_hit),
        .new_blk   ({m_tag, idx}),
        .new_valid (m_valid),
        .new_dirty (m_dirty),
        .drop_wb   (drop_wb)
    );

    // Classify the outcome and plan the line moves.
    always_comb begin
        main_hit = m_valid && (m_tag == tag);
        if (main_hit)   kind = KIND_MAIN;
        else if (v_hit) kind = KIND_VIC;
        else            kind = KIND_MISS;
        m_wr_en    = accept && (is_wr || !main_hit);
        m_wr_dirty = main_hit ? 1'b1 : (v_hit ? (v_dirty || is_wr) : is_wr);
        v_upd      = accept && !main_hit && (v_hit || m_valid);
    end

    dmvc_stats #(
        .CNT_W     (CNT_W),
        .COST_MAIN (COST_MAIN),
        .COST_VIC  (COST_VIC),
        .COST_MISS (COST_MISS)
    ) stats_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (accept),
        .acc_kind (kind),
        .acc_wb   (drop_wb),
        .refs     (cnt_refs),
        .n_main   (cnt_main),
        .n_vic    (cnt_vic),
        .n_miss   (cnt_miss),
        .n_wb     (cnt_wb),
        .cycles   (cnt_cycles)
    );

    // Register the response and the sticky end-of-stream flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= KIND_NONE;
            rsp_wb    <= 1'b0;
            done      <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_kind  <= accept ? kind : KIND_NONE;
            rsp_wb    <= accept && drop_wb;
            if (req_valid && is_end) done <= 1'b1;
        end
    end

    // A line is never resident in both structures at once.
    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !(main_hit && v_hit));

    // Once the end marker is seen the flag holds until reset.
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // A request that is not accepted yields no response.
    p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);

    // A write-back is reported only together with a full miss.
    p_wb_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb |-> (rsp_valid && rsp_kind == 2'd3));
endmodule

// File: tb/dmvc_cache_tb.sv
// Self-checking bench: a directed sequence with hand-derived outcomes, then a long
// conflicting sweep compared against an arithmetic model of the requirements.
module dmvc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = 32'd0;
    logic        rsp_valid, rsp_wb, done;
    logic [1:0]  rsp_kind;
    logic [31:0] cnt_refs, cnt_main, cnt_vic, cnt_miss, cnt_wb, cnt_cycles;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmvc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_wb(rsp_wb), .done(done), .cnt_refs(cnt_refs), .cnt_main(cnt_main),
        .cnt_vic(cnt_vic), .cnt_miss(cnt_miss), .cnt_wb(cnt_wb), .cnt_cycles(cnt_cycles)
    );

    // Model state
    logic [24:0] m_tag [16];
    bit          m_v [16];
    bit          m_d [16];
    logic [28:0] vb_blk [2];
    bit          vb_v [2];
    bit          vb_d [2];
    int          vb_age [2];
    int          e_refs, e_main, e_vic, e_miss, e_wb, e_cyc;

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_d[i] = 0; m_tag[i] = '0; end
        for (int i = 0; i < 2; i++) begin vb_v[i] = 0; vb_d[i] = 0; vb_age[i] = i; vb_blk[i] = '0; end
        e_refs = 0; e_main = 0; e_vic = 0; e_miss = 0; e_wb = 0; e_cyc = 0;
    endtask

    task automatic touch(int s);
        for (int j = 0; j < 2; j++)
            if (j != s && vb_age[j] < vb_age[s]) vb_age[j]++;
        vb_age[s] = 0;
    endtask

    task automatic model_ref(logic [1:0] op, logic [31:0] a, output int kind, output bit wb);
        int  ix;
        int  s;
        bit  wr;
        bit  od;
        ix = int'(a[6:3]);
        wr = (op == 2'd2);
        wb = 0;
        s  = -1;
        if (m_v[ix] && m_tag[ix] == a[31:7]) begin
            kind = 1;
            if (wr) m_d[ix] = 1;
        end else begin
            for (int j = 0; j < 2; j++) if (vb_v[j] && vb_blk[j] == a[31:3]) s = j;
            if (s >= 0) begin
                kind = 2;
                od = vb_d[s];
                vb_blk[s] = {m_tag[ix], a[6:3]}; vb_v[s] = m_v[ix]; vb_d[s] = m_d[ix];
                touch(s);
                m_d[ix] = od | wr;
            end else begin
                kind = 3;
                if (m_v[ix]) begin
                    for (int j = 1; j >= 0; j--) if (!vb_v[j]) s = j;
                    if (s < 0) s = (vb_age[0] == 1) ? 0 : 1;
                    wb = vb_v[s] && vb_d[s];
                    vb_blk[s] = {m_tag[ix], a[6:3]}; vb_v[s] = 1; vb_d[s] = m_d[ix];
                    touch(s);
                end
                m_d[ix] = wr;
            end
            m_tag[ix] = a[31:7];
            m_v[ix] = 1;
        end
        e_refs++;
        if (wb) e_wb++;
        case (kind)
            1: begin e_main++; e_cyc += 1; end
            2: begin e_vic++;  e_cyc += 2; end
            default: begin e_miss++; e_cyc += 50; end
        endcase
    endtask

    // Drive one request for one cycle; outputs are then read at the following negedge.
    task automatic send(logic [1:0] op, logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_counts(string req);
        check({req, " refs"},   cnt_refs,   e_refs);
        check({req, " main"},   cnt_main,   e_main);
        check({req, " vic"},    cnt_vic,    e_vic);
        check({req, " miss"},   cnt_miss,   e_miss);
        check({req, " wb"},     cnt_wb,     e_wb);
        check({req, " cycles"}, cnt_cycles, e_cyc);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int          kind;
        bit          wb;
        logic [31:0] seq_a [9];
        logic [1:0]  seq_o [9];
        int          exp_k [9];
        bit          exp_w [9];
        logic [31:0] lcg;
        logic [31:0] snap_refs, snap_cyc;

        do_reset();
        // R11 reset state
        check("R11 rsp_valid", rsp_valid, 0);
        check("R11 done", done, 0);
        check_counts("R11");

        // Directed: set 0 conflicts among blocks A,B,C,D,E (tags 0..4)
        seq_a = '{32'h000, 32'h004, 32'h080, 32'h000, 32'h080, 32'h100, 32'h180, 32'h200, 32'h100};
        seq_o = '{2'd1, 2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd2, 2'd1, 2'd1};
        exp_k = '{3, 1, 3, 2, 2, 3, 3, 3, 2};
        exp_w = '{0, 0, 0, 0, 0, 0, 0, 1, 0};
        for (int i = 0; i < 9; i++) begin
            send(seq_o[i], seq_a[i]);
            model_ref(seq_o[i], seq_a[i], kind, wb);
            check("R2 rsp_valid", rsp_valid, 1);
            check("R1 R3 R4 kind", rsp_kind, exp_k[i]);
            check("R5 R6 wb", rsp_wb, exp_w[i]);
        end
        check("R7 refs", cnt_refs, 9);
        check("R7 main", cnt_main, 1);
        check("R7 vic", cnt_vic, 3);
        check("R7 miss", cnt_miss, 5);
        check("R5 wb count", cnt_wb, 1);
        check("R8 cycles", cnt_cycles, 257);

        // R10: illegal operations leave everything unchanged
        send(2'd3, 32'h000);
        check("R10 op3 no rsp", rsp_valid, 0);
        send(2'd0, 32'h040);
        check("R10 op0 nonzero no rsp", rsp_valid, 0);
        check("R10 done", done, 0);
        check_counts("R10");
        send(2'd1, 32'h100);   // C still in main: hit proves no state moved
        model_ref(2'd1, 32'h100, kind, wb);
        check("R10 state kept", rsp_kind, 1);

        // R9: end marker then ignored traffic
        send(2'd0, 32'h0);
        check("R9 done", done, 1);
        check("R9 marker no rsp", rsp_valid, 0);
        snap_refs = cnt_refs; snap_cyc = cnt_cycles;
        send(2'd1, 32'h300);
        check("R9 ignored rsp", rsp_valid, 0);
        check("R9 refs held", cnt_refs, snap_refs);
        check("R9 cycles held", cnt_cycles, snap_cyc);

        // R11: reset clears lines too
        do_reset();
        check("R11 done cleared", done, 0);
        send(2'd1, 32'h100);
        model_ref(2'd1, 32'h100, kind, wb);
        check("R11 line invalid", rsp_kind, 3);

        // Sweep: 4 tags x 4 sets, mixed reads and writes, compared with the model
        lcg = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            logic [1:0]  o;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = ({30'd0, lcg[21:20]} << 7) | ({30'd0, lcg[17:16]} << 3) | {29'd0, lcg[14:12]};
            o = lcg[24] ? 2'd2 : 2'd1;
            send(o, a);
            model_ref(o, a, kind, wb);
            check("R3 R4 R6 sweep kind", rsp_kind, kind);
            check("R5 R6 sweep wb", rsp_wb, wb);
        end
        check_counts("R7 R8 sweep");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule